// File: doc/BRIEF.md
# Lockable Eight-Way Tag Directory

This block is the tag side of a 32-Kbyte, eight-way set-associative, physically addressed cache. It holds the tag, valid bit and lock bit of every line, plus a pseudo-LRU tree for each set. It answers a lookup with hit or miss, the way that hit, or the way chosen for replacement. A line can be pinned with a lock so that it is never chosen for replacement. This keeps time-critical code or data resident and gives a fixed access time. Lock and unlock requests need no privilege. Instruction and data traffic each get their own instance of the same module.

A request carries a physical address and an operation: read, write, lock or unlock. The block looks up the indexed set and reports the result one cycle later. On an allocating miss it raises a fill handshake that names the victim way. When the fill is acknowledged, the new tag is written into that way. A flash-clear input drops every lock bit in one cycle and leaves tags and valid bits alone. The data array and the bus refill are outside the block.

The controller has three states. `ST_IDLE` accepts requests. `ST_COMPARE` presents the response. `ST_FILL` waits for the refill acknowledge. There are four transitions:
- ACCEPT: `ST_IDLE` to `ST_COMPARE` when `req_valid` is high.
- DONE: `ST_COMPARE` to `ST_IDLE` on a hit or on a miss that does not allocate.
- ALLOCATE: `ST_COMPARE` to `ST_FILL` on a miss that allocates.
- REFILL: `ST_FILL` to `ST_IDLE` on `fill_ack`.

Top module: `lkc_tag_dir`

## Requirements
- R1: After reset, every valid bit, lock bit and tree bit is zero. `req_ready` is 1, and `rsp_valid` and `fill_req` are 0. The first miss in any set therefore names way 0 as its victim.
- R2: The address splits into three fields: byte offset in bits [4:0], set index in bits [11:5] (128 sets) and tag in bits [31:12]. A request accepted while `req_ready` is high gives `rsp_valid` for exactly the next cycle. `req_ready` is low from that cycle until the block returns to idle.
- R3: `req_op` is encoded as follows: 0 = read, 1 = write, 2 = lock, 3 = unlock. `rsp_hit` is 1 when a valid way of the indexed set holds the request tag. `rsp_way` then gives that way, and at most one way ever matches.
- R4: The tree has seven bits per set: node 0 is the root and nodes 2n+1 and 2n+2 are the children of node n. A bit of 0 points the victim search at the lower-numbered half of the node's range. When the pointed half holds no unlocked way, the search takes the other half.
- R5: A hit, and a completed fill, make the accessed way most recently used. Every tree node on its path is set to point away from it.
- R6: Locked ways are never victims. If all eight ways of the set are locked, a miss reports `rsp_no_alloc` = 1, raises no fill and changes no state.
- R7: A read or lock miss with an unlocked way available raises `fill_req`, with `fill_way` equal to the reported victim. Both hold until `fill_ack`, and in that cycle the tag and valid bit are written. A write miss allocates nothing and reports `rsp_no_alloc` = 1.
- R8: A lock that hits sets the lock bit of the hit way. A lock that misses allocates like a read and locks the filled way. An unlock that hits clears the lock bit. An unlock that misses changes nothing and reports `rsp_no_alloc` = 1.
- R9: `clr_locks` clears every lock bit at the next edge and keeps all tags and valid bits.
- R10: A lock bit set in the same cycle as `clr_locks`, by a lock hit or by a lock fill's acknowledge, survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 lock, 3 unlock |
| req_addr | input | 32 | Physical byte address |
| clr_locks | input | 1 | Flash-clear of all lock bits |
| rsp_valid | output | 1 | Response fields valid this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Hit way |
| rsp_victim | output | 3 | Replacement way on an allocating miss |
| rsp_no_alloc | output | 1 | Miss that allocates no line |
| fill_req | output | 1 | Refill pending for the victim way |
| fill_way | output | 3 | Way the refill writes |
| fill_ack | input | 1 | Refill complete; write the tag |

## Verification
Two functions can fall in the same cycle: the flash-clear and a lock-bit write. That write comes either from a lock hit in the compare cycle or from a lock fill's acknowledge. The bench raises `clr_locks` in exactly those cycles. It then re-locks every other line of the set and issues a miss. The miss must report no allocation, which proves that the new lock survived while the old ones were cleared. A behavioural model that processes the clear before the lock write judges every cycle of directed and random traffic, including these collisions.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_LOCK   = 2'd2,
        OP_UNLOCK = 2'd3
    } lkc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_FILL    = 2'd2
    } lkc_state_e;

endpackage

// File: rtl/lkc_way_match.sv
module lkc_way_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = set_valid[g] && (set_tags[g] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/lkc_victim_pick.sv
module lkc_victim_pick #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree,
    input  logic [WAYS-1:0]  locked,
    output logic [WAY_W-1:0] victim,
    output logic             all_locked
);
    int   node;
    int   base;
    int   half;
    logic go_hi;
    logic lo_ok;
    logic hi_ok;

    always_comb begin
        node  = 0;
        base  = 0;
        half  = 0;
        go_hi = 1'b0;
        lo_ok = 1'b0;
        hi_ok = 1'b0;
        for (int lv = 0; lv < WAY_W; lv++) begin
            half  = WAYS >> (lv + 1);
            lo_ok = 1'b0;
            hi_ok = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (w >= base && w < base + half && !locked[w]) lo_ok = 1'b1;
                if (w >= base + half && w < base + 2 * half && !locked[w]) hi_ok = 1'b1;
            end
            go_hi = tree[node];
            if (!go_hi && !lo_ok)     go_hi = 1'b1;
            else if (go_hi && !hi_ok) go_hi = 1'b0;
            if (go_hi) base = base + half;
            node = 2 * node + 1 + (go_hi ? 1 : 0);
        end
        victim = WAY_W'(base);
    end

    assign all_locked = &locked;
endmodule

// File: rtl/lkc_plru_update.sv
module lkc_plru_update #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  cur_tree,
    input  logic [WAY_W-1:0] used_way,
    output logic [WAYS-2:0]  nxt_tree
);
    int   node;
    logic upper;

    always_comb begin
        nxt_tree = cur_tree;
        node     = 0;
        upper    = 1'b0;
        for (int lv = 0; lv < WAY_W; lv++) begin
            upper          = used_way[WAY_W-1-lv];
            nxt_tree[node] = ~upper;
            node           = 2 * node + 1 + (upper ? 1 : 0);
        end
    end
endmodule

// File: rtl/lkc_tag_dir.sv
module lkc_tag_dir #(
    parameter int ADDR_W     = 32,
    parameter int CAP_BYTES  = 32768,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 32,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              clr_locks,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [WAY_W-1:0]  rsp_victim,
    output logic              rsp_no_alloc,
    output logic              fill_req,
    output logic [WAY_W-1:0]  fill_way,
    input  logic              fill_ack
);
    import lkc_pkg::*;

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SETS  = CAP_BYTES / (LINE_BYTES * WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    lkc_state_e state_q, state_d;
    lkc_op_e    op_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] look_tag_q;
    logic [WAY_W-1:0] victim_q;

    logic [WAYS-1:0][TAG_W-1:0] tag_mem   [SETS];
    logic [WAYS-1:0]            valid_mem [SETS];
    logic [WAYS-1:0]            lock_mem  [SETS];
    logic [WAYS-2:0]            tree_mem  [SETS];

    logic [WAYS-1:0]  hit_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] pick_way;
    logic             all_locked;
    logic [WAYS-2:0]  tree_nxt;
    logic             in_cmp, in_fill, alloc_miss, do_fill;
    logic             do_touch, set_lock, drop_lock;
    logic [WAY_W-1:0] act_way;

    lkc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tags (tag_mem[idx_q]),
        .set_valid(valid_mem[idx_q]),
        .look_tag (look_tag_q),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    lkc_victim_pick #(.WAYS(WAYS)) u_pick (
        .tree      (tree_mem[idx_q]),
        .locked    (lock_mem[idx_q]),
        .victim    (pick_way),
        .all_locked(all_locked)
    );

    lkc_plru_update #(.WAYS(WAYS)) u_touch (
        .cur_tree(tree_mem[idx_q]),
        .used_way(act_way),
        .nxt_tree(tree_nxt)
    );

    assign in_cmp     = (state_q == ST_COMPARE);
    assign in_fill    = (state_q == ST_FILL);
    assign alloc_miss = !hit && !all_locked && (op_q == OP_READ || op_q == OP_LOCK);
    assign do_fill    = in_fill && fill_ack;
    assign act_way    = in_fill ? victim_q : hit_way;
    assign do_touch   = (in_cmp && hit) || do_fill;
    assign set_lock   = (op_q == OP_LOCK) && ((in_cmp && hit) || do_fill);
    assign drop_lock  = in_cmp && hit && (op_q == OP_UNLOCK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_COMPARE;
            ST_COMPARE: state_d = alloc_miss ? ST_FILL : ST_IDLE;
            ST_FILL:    if (fill_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = in_cmp;
        rsp_hit      = in_cmp && hit;
        rsp_way      = hit_way;
        rsp_victim   = pick_way;
        rsp_no_alloc = in_cmp && !hit && !alloc_miss;
        fill_req     = in_fill;
        fill_way     = victim_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            idx_q      <= '0;
            look_tag_q <= '0;
            victim_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q       <= lkc_op_e'(req_op);
                idx_q      <= req_addr[OFF_W +: IDX_W];
                look_tag_q <= req_addr[ADDR_W-1 -: TAG_W];
            end
            if (in_cmp) victim_q <= pick_way;
        end
    end

    always_ff @(posedge clk) begin
        if (do_fill) tag_mem[idx_q][victim_q] <= look_tag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_mem[s] <= '0;
                lock_mem[s]  <= '0;
                tree_mem[s]  <= '0;
            end
        end else begin
            if (do_fill)  valid_mem[idx_q][victim_q] <= 1'b1;
            if (do_touch) tree_mem[idx_q] <= tree_nxt;
            if (clr_locks) begin
                for (int s = 0; s < SETS; s++) lock_mem[s] <= '0;
            end
            if (set_lock)       lock_mem[idx_q][act_way] <= 1'b1;
            else if (drop_lock) lock_mem[idx_q][act_way] <= 1'b0;
        end
    end

    logic lock_any;
    always_comb begin
        lock_any = 1'b0;
        for (int s = 0; s < SETS; s++) lock_any = lock_any | (|lock_mem[s]);
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(hit_vec)); // R3
    AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_no_alloc) |-> !lock_mem[idx_q][rsp_victim]); // R6
    AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_way))); // R7
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && op_q == OP_LOCK) |=> lock_mem[$past(idx_q)][$past(rsp_way)]); // R8
    AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_locks && !set_lock) |=> !lock_any); // R9
endmodule

// File: tb/tb_lkc_tag_dir.sv
`timescale 1ns/1ps
module tb_lkc_tag_dir;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, LK = 2'd2, UL = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic clr_locks = 1'b0;
    logic fill_ack = 1'b0;
    logic req_ready, rsp_valid, rsp_hit, rsp_no_alloc, fill_req;
    logic [2:0] rsp_way, rsp_victim, fill_way;

    always #2.5 clk = ~clk;

    lkc_tag_dir dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .clr_locks(clr_locks),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim(rsp_victim), .rsp_no_alloc(rsp_no_alloc),
        .fill_req(fill_req), .fill_way(fill_way), .fill_ack(fill_ack)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_tag [128][8];
    bit m_val [128][8];
    bit m_lck [128][8];
    bit m_pl  [128][7];
    int m_state = 0;            // 0 idle, 1 compare, 2 fill
    int m_op = 0, m_set = 0, m_tg = 0, m_vic = 0;

    function automatic int find_hit(int s, int t);
        for (int w = 0; w < 8; w++) if (m_val[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic bit full_locked(int s);
        for (int w = 0; w < 8; w++) if (!m_lck[s][w]) return 0;
        return 1;
    endfunction

    function automatic int pick(int s);
        int lo, hi, n, mid;
        bit l, r, go;
        lo = 0; hi = 8; n = 0;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            l = 0; r = 0;
            for (int w = lo; w < mid; w++) if (!m_lck[s][w]) l = 1;
            for (int w = mid; w < hi; w++) if (!m_lck[s][w]) r = 1;
            go = m_pl[s][n];
            if (!go && !l) go = 1; else if (go && !r) go = 0;
            if (go) lo = mid; else hi = mid;
            n = 2 * n + 1 + int'(go);
        end
        return lo;
    endfunction

    task automatic touch(int s, int way);
        int lo, hi, n, mid;
        bit go;
        lo = 0; hi = 8; n = 0;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            go = (way >= mid);
            m_pl[s][n] = !go;
            if (go) lo = mid; else hi = mid;
            n = 2 * n + 1 + int'(go);
        end
    endtask

    function automatic bit exp_noalloc();
        return find_hit(m_set, m_tg) < 0 &&
               (m_op == WR || m_op == UL || full_locked(m_set));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 128; s++)
                for (int w = 0; w < 8; w++) begin
                    m_val[s][w] = 0; m_lck[s][w] = 0;
                    if (w < 7) m_pl[s][w] = 0;
                end
            m_state = 0;
        end else begin
            int h, v;
            bit nal;
            h = 0; v = 0; nal = 0;
            if (m_state == 1) begin
                h = find_hit(m_set, m_tg);
                v = pick(m_set);
                nal = exp_noalloc();
            end
            if (clr_locks)
                for (int s = 0; s < 128; s++)
                    for (int w = 0; w < 8; w++) m_lck[s][w] = 0;
            case (m_state)
                0: if (req_valid) begin
                    m_op = int'(req_op); m_set = int'(req_addr[11:5]);
                    m_tg = int'(req_addr[31:12]); m_state = 1;
                end
                1: begin
                    if (h >= 0) begin
                        touch(m_set, h);
                        if (m_op == LK) m_lck[m_set][h] = 1;
                        if (m_op == UL) m_lck[m_set][h] = 0;
                        m_state = 0;
                    end else if (nal) m_state = 0;
                    else begin m_vic = v; m_state = 2; end
                end
                default: if (fill_ack) begin
                    m_tag[m_set][m_vic] = m_tg;
                    m_val[m_set][m_vic] = 1;
                    touch(m_set, m_vic);
                    if (m_op == LK) m_lck[m_set][m_vic] = 1;
                    m_state = 0;
                end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int h;
            chk(req_ready == (m_state == 0), "R2 req_ready", int'(req_ready), int'(m_state == 0));
            chk(rsp_valid == (m_state == 1), "R2 rsp_valid", int'(rsp_valid), int'(m_state == 1));
            chk(fill_req == (m_state == 2), "R7 fill_req", int'(fill_req), int'(m_state == 2));
            if (m_state == 1) begin
                h = find_hit(m_set, m_tg);
                chk(rsp_hit == (h >= 0), "R3 rsp_hit", int'(rsp_hit), int'(h >= 0));
                if (h >= 0) chk(int'(rsp_way) == h, "R3 rsp_way", int'(rsp_way), h);
                chk(rsp_no_alloc == exp_noalloc(), "R6 rsp_no_alloc", int'(rsp_no_alloc), int'(exp_noalloc()));
                if (h < 0 && !exp_noalloc())
                    chk(int'(rsp_victim) == pick(m_set), "R4 rsp_victim", int'(rsp_victim), pick(m_set));
            end
            if (m_state == 2) chk(int'(fill_way) == m_vic, "R7 fill_way", int'(fill_way), m_vic);
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] mk(int t, int s);
        return {t[19:0], s[6:0], 5'(s * 3)};
    endfunction

    bit r_hit, r_na, r_fill;
    int r_way, r_vic;

    // clr_mode: 0 none, 1 during compare, 2 with fill acknowledge
    task automatic op(input logic [1:0] o, input logic [31:0] a, input int clr_mode, input int dly);
        req_valid = 1; req_op = o; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        r_hit = rsp_hit; r_way = int'(rsp_way); r_vic = int'(rsp_victim); r_na = rsp_no_alloc;
        clr_locks = (clr_mode == 1);
        @(negedge clk);
        clr_locks = 0;
        r_fill = fill_req;
        if (fill_req) begin
            repeat (dly) @(negedge clk);
            fill_ack = 1; clr_locks = (clr_mode == 2);
            @(negedge clk);
            fill_ack = 0; clr_locks = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 0 && fill_req == 0, "R1 idle outputs", int'(rsp_valid | fill_req), 0);

        // fresh set fills: victims 0 then 4 per tree encoding
        op(RD, mk(256, 5), 0, 1);
        chk(!r_hit && r_vic == 0, "R1 first victim", r_vic, 0);
        op(RD, mk(256, 5), 0, 0);
        chk(r_hit && r_way == 0, "R2 hit after fill", r_way, 0);
        op(RD, mk(257, 5), 0, 2);
        chk(r_vic == 4, "R4 second victim", r_vic, 4);
        for (int t = 258; t < 264; t++) op(RD, mk(t, 5), 0, 0);
        for (int t = 256; t < 264; t++) begin
            op(RD, mk(t, 5), 0, 0);
            chk(r_hit == 1, "R3 all eight resident", int'(r_hit), 1);
        end
        op(RD, mk(259, 5), 0, 0);
        begin
            int mru;
            mru = r_way;
            op(WR, mk(300, 5), 0, 0);
            chk(r_na == 1 && r_fill == 0, "R7 write miss no allocate", int'(r_na), 1);
            op(RD, mk(300, 5), 0, 0);
            chk(r_vic != mru, "R5 MRU way not victim", r_vic, mru);
        end

        // lock every line of set 5
        for (int t = 257; t < 264; t++) begin
            op(LK, mk(t, 5), 0, 0);
            chk(r_hit == 1, "R8 lock hit", int'(r_hit), 1);
        end
        op(LK, mk(300, 5), 0, 0);
        op(RD, mk(400, 5), 0, 0);
        chk(r_na == 1 && r_fill == 0, "R6 all locked no fill", int'(r_na), 1);
        op(UL, mk(260, 5), 0, 0);
        begin
            int freed;
            freed = r_way;
            op(RD, mk(401, 5), 0, 0);
            chk(r_vic == freed && r_fill == 1, "R8 unlocked way reused", r_vic, freed);
        end
        op(UL, mk(999, 5), 0, 0);
        chk(r_na == 1, "R8 unlock miss", int'(r_na), 1);

        // flash clear keeps tags
        clr_locks = 1; @(negedge clk); clr_locks = 0;
        op(RD, mk(261, 5), 0, 0);
        chk(r_hit == 1, "R9 tags kept after clear", int'(r_hit), 1);
        op(RD, mk(402, 5), 0, 0);
        chk(r_na == 0 && r_fill == 1, "R9 locks cleared", int'(r_na), 0);

        // lock miss allocates and locks
        op(LK, mk(50, 9), 0, 1);
        chk(r_fill == 1, "R7 lock miss fills", int'(r_fill), 1);
        op(RD, mk(50, 9), 0, 0);
        chk(r_hit == 1, "R8 locked fill resident", int'(r_hit), 1);

        // clear collides with lock hit
        for (int t = 0; t < 8; t++) op(RD, mk(t, 12), 0, 0);
        for (int t = 0; t < 7; t++) op(LK, mk(t, 12), 0, 0);
        op(LK, mk(7, 12), 1, 0);
        for (int t = 0; t < 7; t++) op(LK, mk(t, 12), 0, 0);
        op(RD, mk(77, 12), 0, 0);
        chk(r_na == 1, "R10 lock hit survives clear", int'(r_na), 1);

        // clear collides with lock fill acknowledge
        for (int t = 0; t < 8; t++) op(RD, mk(t, 13), 0, 0);
        for (int t = 0; t < 7; t++) op(LK, mk(t, 13), 0, 0);
        op(LK, mk(90, 13), 2, 1);
        for (int t = 0; t < 7; t++) op(LK, mk(t, 13), 0, 0);
        op(RD, mk(91, 13), 0, 0);
        chk(r_na == 1, "R10 lock fill survives clear", int'(r_na), 1);

        // random traffic, judged cycle by cycle by the model
        for (int i = 0; i < 3000; i++) begin
            int cm;
            cm = ($urandom_range(0, 15) == 0) ? int'($urandom_range(1, 2)) : 0;
            op(2'($urandom_range(0, 3)), mk(int'($urandom_range(0, 11)), int'($urandom_range(0, 3))),
               cm, int'($urandom_range(0, 3)));
            if ($urandom_range(0, 7) == 0) @(negedge clk);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule